// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of prioritized interrupt request lines and a processor sequencer. Each incoming request is caught in a pending register and held there until the core accepts it. The block arbitrates among the pending requests that are allowed through. It presents a single vectored request that carries the index of the winner, so the core can branch to the matching routine.

An in-service register holds one bit per interrupt. Bits are arranged by priority, and each set bit is a temporary mask for one active service level. When the core enters a routine it raises an acknowledge. That marks the winner as in service and drops its pending bit. A return strobe at the end of the routine retires the level entered most recently. A nesting-enable bit chooses between two behaviours. With nesting on, a strictly more urgent pending request preempts the running routine. With nesting off, nothing new is issued until every routine has returned. A global enable and a per-line enable gate arbitration. Requests that are held back are never lost. They are served in priority order once the blocking levels retire.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, the pending bits and the in-service bits are all zero and `req_valid` is low.
- R2: A high `irq_in[i]` sets `pend_o[i]` at the next clock edge, and the bit stays set until that interrupt is acknowledged.
- R3: `req_valid` is high when at least one pending bit is eligible. `req_idx` is then the lowest eligible index, since index 0 is the most urgent.
- R4: A pending bit is eligible only when its `irq_en` bit is 1 and `glob_en` is 1. A request held back by either enable stays pending.
- R5: An `ack` while `req_valid` is high sets `inserv_o[req_idx]` and clears `pend_o[req_idx]` at the next edge. An `ack` while `req_valid` is low has no effect.
- R6: If `irq_in[i]` is high in the same cycle that interrupt `i` is acknowledged, `pend_o[i]` stays set.
- R7: With `nest_en`=1, a pending interrupt is eligible only if its index is lower than every set `inserv_o` bit.
- R8: With `nest_en`=0, `req_valid` stays low while any `inserv_o` bit is set.
- R9: `rtn` clears the lowest-index set bit of `inserv_o` at the next edge. It has no effect when no bit is set.
- R10: Requests held back during nested service are issued in priority order as the levels return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N_IRQ | Request lines, index 0 most urgent |
| irq_en | input | N_IRQ | Per-line enable, 1 lets the line compete |
| glob_en | input | 1 | Global enable for issuing requests |
| nest_en | input | 1 | 1 allows preemption by more urgent lines |
| ack | input | 1 | Core accepts the presented request |
| rtn | input | 1 | Core leaves the most recently entered routine |
| req_valid | output | 1 | A request is being presented |
| req_idx | output | IDX_W | Index of the presented request |
| pend_o | output | N_IRQ | Pending register |
| inserv_o | output | N_IRQ | In-service register, one temporary mask bit per line |

## Verification
Two collisions can happen in one cycle. The first is a new request on a line at the moment that same line is acknowledged. The bench drives `irq_in` and `ack` for one line on the same edge. It then expects the line to be both in service and still pending, and it expects no new request for that line while its level is active. The second is a return arriving while requests held back during nesting are waiting. The bench builds a stack of three levels with deeper requests pending. It checks after each `rtn` that exactly the most urgent active level has cleared and that the next pending line in priority order appears. Around these cases it sweeps every pending pattern against every enable pattern, and every single active level against every pending pattern in both nesting modes.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
   localparam int NIRQ_MAX = 32;

   typedef struct packed {
      logic       hit;
      logic [4:0] idx;
   } nirq_pick_t;

   // lowest set index of a vector, flagged by hit
   function automatic nirq_pick_t nirq_first(input logic [NIRQ_MAX-1:0] v);
      nirq_pick_t r;
      r.hit = 1'b0;
      r.idx = '0;
      for (int i = NIRQ_MAX - 1; i >= 0; i--) begin
         if (v[i]) begin
            r.hit = 1'b1;
            r.idx = 5'(i);
         end
      end
      return r;
   endfunction
endpackage

// File: rtl/nirq_pend.sv
module nirq_pend #(
   parameter int N_IRQ = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] set_i,
   input  logic [N_IRQ-1:0] clr_i,
   output logic [N_IRQ-1:0] pend_q
);
   // one flop per line; a new request wins over a clear in the same cycle (R6)
   for (genvar g = 0; g < N_IRQ; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q[g] <= 1'b0;
         else if (set_i[g])
            pend_q[g] <= 1'b1;
         else if (clr_i[g])
            pend_q[g] <= 1'b0;
      end

      p_catch_r2: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> pend_q[g]);

      p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[g] && !set_i[g]) |=> !pend_q[g]);
   end
endmodule

// File: rtl/nirq_inserv.sv
module nirq_inserv #(
   parameter int N_IRQ = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enter_i,
   input  logic [IDX_W-1:0] enter_idx_i,
   input  logic             leave_i,
   output logic [N_IRQ-1:0] lvl_q
);
   logic [N_IRQ-1:0] enter_oh;
   logic [N_IRQ-1:0] after_leave;

   always_comb begin
      enter_oh = '0;
      if (enter_i)
         enter_oh[enter_idx_i] = 1'b1;
   end

   // clearing the lowest set bit retires the most urgent, most recent level (R9)
   assign after_leave = leave_i ? (lvl_q & (lvl_q - 1'b1)) : lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl_q <= '0;
      else
         lvl_q <= after_leave | enter_oh;
   end

   p_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
      enter_i |=> lvl_q[$past(enter_idx_i)]);

   p_leave_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (leave_i && !enter_i && lvl_q != '0) |=>
         ($countones(lvl_q) + 1 == $countones($past(lvl_q))));

   p_leave_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (leave_i && !enter_i && lvl_q == '0) |=> lvl_q == '0);
endmodule

// File: rtl/nirq_arb.sv
module nirq_arb
   import nirq_pkg::*;
#(
   parameter int N_IRQ        = 8,
   parameter int IDX_W        = 3,
   parameter bit NEST_SUPPORT = 1'b1
) (
   input  logic [N_IRQ-1:0] pend_i,
   input  logic [N_IRQ-1:0] en_i,
   input  logic             glob_en_i,
   input  logic             nest_en_i,
   input  logic [N_IRQ-1:0] lvl_i,
   output logic             win_vld_o,
   output logic [IDX_W-1:0] win_idx_o
);
   logic [N_IRQ-1:0] blk;
   logic [N_IRQ-1:0] elig;
   logic             busy;
   nirq_pick_t       pick;

   // line i is blocked if any level at index <= i is active (R7)
   assign blk[0] = lvl_i[0];
   for (genvar g = 1; g < N_IRQ; g++) begin : g_pfx
      assign blk[g] = blk[g-1] | lvl_i[g];
   end

   assign busy = |lvl_i;

   if (NEST_SUPPORT) begin : g_nest
      always_comb begin
         if (!nest_en_i && busy)
            elig = '0;
         else
            elig = pend_i & en_i & {N_IRQ{glob_en_i}} & ~blk;
      end
   end else begin : g_flat
      always_comb begin
         if (busy)
            elig = '0;
         else
            elig = pend_i & en_i & {N_IRQ{glob_en_i}};
      end
   end

   assign pick      = nirq_first(NIRQ_MAX'(elig));
   assign win_vld_o = pick.hit;
   assign win_idx_o = pick.idx[IDX_W-1:0];
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
   parameter int N_IRQ        = 8,
   parameter bit NEST_SUPPORT = 1'b1,
   localparam int IDX_W       = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             glob_en,
   input  logic             nest_en,
   input  logic             ack,
   input  logic             rtn,
   output logic             req_valid,
   output logic [IDX_W-1:0] req_idx,
   output logic [N_IRQ-1:0] pend_o,
   output logic [N_IRQ-1:0] inserv_o
);
   if (N_IRQ < 2 || N_IRQ > nirq_pkg::NIRQ_MAX) begin : g_chk
      $error("nest_irq_ctrl: N_IRQ out of range");
   end

   localparam logic [N_IRQ-1:0] ALL1 = {N_IRQ{1'b1}};

   logic             take;
   logic [N_IRQ-1:0] take_oh;

   assign take = ack & req_valid;   // ack without a request is ignored (R5)

   always_comb begin
      take_oh = '0;
      if (take)
         take_oh[req_idx] = 1'b1;
   end

   nirq_pend #(.N_IRQ(N_IRQ)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (irq_in),
      .clr_i  (take_oh),
      .pend_q (pend_o)
   );

   nirq_inserv #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_lvl (
      .clk         (clk),
      .rst_n       (rst_n),
      .enter_i     (take),
      .enter_idx_i (req_idx),
      .leave_i     (rtn),
      .lvl_q       (inserv_o)
   );

   nirq_arb #(.N_IRQ(N_IRQ), .IDX_W(IDX_W), .NEST_SUPPORT(NEST_SUPPORT)) u_arb (
      .pend_i    (pend_o),
      .en_i      (irq_en),
      .glob_en_i (glob_en),
      .nest_en_i (nest_en),
      .lvl_i     (inserv_o),
      .win_vld_o (req_valid),
      .win_idx_o (req_idx)
   );

   p_win_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (pend_o[req_idx] && irq_en[req_idx] && glob_en));

   p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ((inserv_o & ~(ALL1 << (32'(req_idx) + 32'd1))) == '0));

   p_flat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !nest_en) |-> (inserv_o == '0));

   p_flat_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !nest_en) |=> $onehot0(inserv_o));
endmodule

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic [N-1:0] irq_en = '1;
   logic         glob_en = 1'b1;
   logic         nest_en = 1'b1;
   logic         ack = 1'b0;
   logic         rtn = 1'b0;
   logic         req_valid;
   logic [1:0]   req_idx;
   logic [N-1:0] pend_o;
   logic [N-1:0] inserv_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   nest_irq_ctrl #(.N_IRQ(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_en(irq_en),
      .glob_en(glob_en), .nest_en(nest_en), .ack(ack), .rtn(rtn),
      .req_valid(req_valid), .req_idx(req_idx), .pend_o(pend_o),
      .inserv_o(inserv_o)
   );

   function automatic int lowest(input int v);
      for (int i = 0; i < N; i++)
         if (v[i]) return i;
      return -1;
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // expected winner: -1 means no request
   task automatic chk_req(input string rq, input int exp);
      int act;
      act = req_valid ? int'(req_idx) : -1;
      chk(act == exp, rq, act, exp);
   endtask

   task automatic cyc();
      @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; irq_in = '0; ack = 1'b0; rtn = 1'b0;
      irq_en = '1; glob_en = 1'b1; nest_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic load(input logic [N-1:0] p);
      @(negedge clk);
      irq_in = p;
      @(negedge clk);
      irq_in = '0;
      #1;
   endtask

   task automatic pulse_ack();
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      #1;
   endtask

   task automatic pulse_rtn();
      @(negedge clk);
      rtn = 1'b1;
      @(negedge clk);
      rtn = 1'b0;
      #1;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      chk(pend_o == '0, "R1 pend", int'(pend_o), 0);
      chk(inserv_o == '0, "R1 inserv", int'(inserv_o), 0);
      chk_req("R1 req", -1);

      // R2, R3, R4: every pending pattern against every enable pattern
      for (int p = 0; p < 16; p++) begin
         do_reset();
         load(N'(p));
         chk(pend_o == N'(p), "R2 latched", int'(pend_o), p);
         for (int m = 0; m < 16; m++) begin
            for (int g = 0; g < 2; g++) begin
               irq_en = N'(m);
               glob_en = g[0];
               #1;
               chk_req((m == 15 && g == 1) ? "R3 arbitration" : "R4 enables",
                       (g == 1) ? lowest(p & m) : -1);
            end
         end
         irq_en = '0;
         cyc();
         chk(pend_o == N'(p), "R4 held pending", int'(pend_o), p);
      end

      // R5, R7, R8: one active level h against every pending pattern
      for (int h = 0; h < N; h++) begin
         for (int p = 0; p < 16; p++) begin
            do_reset();
            load(N'(1 << h));
            pulse_ack();
            chk(inserv_o == N'(1 << h), "R5 enter", int'(inserv_o), 1 << h);
            chk(pend_o == '0, "R5 clear", int'(pend_o), 0);
            load(N'(p));
            nest_en = 1'b1;
            #1;
            chk_req("R7 nesting on", lowest(p & ((1 << h) - 1)));
            nest_en = 1'b0;
            #1;
            chk_req("R8 nesting off", -1);
         end
      end

      // R5: ack with no request is ignored
      do_reset();
      glob_en = 1'b0;
      load(4'b0001);
      pulse_ack();
      chk(inserv_o == '0, "R5 stray ack inserv", int'(inserv_o), 0);
      chk(pend_o == 4'b0001, "R5 stray ack pend", int'(pend_o), 1);

      // R6: request and ack of the same line in one cycle
      do_reset();
      load(4'b0100);
      @(negedge clk);
      ack = 1'b1;
      irq_in = 4'b0100;
      @(negedge clk);
      ack = 1'b0;
      irq_in = '0;
      #1;
      chk(inserv_o == 4'b0100, "R6 inserv", int'(inserv_o), 4);
      chk(pend_o == 4'b0100, "R6 still pending", int'(pend_o), 4);
      chk_req("R6 blocked by own level", -1);

      // R9, R10: three nested levels, then unwinding
      do_reset();
      load(4'b1000);
      pulse_ack();
      load(4'b0100);
      chk_req("R7 preempt 2", 2);
      pulse_ack();
      chk(inserv_o == 4'b1100, "R7 two levels", int'(inserv_o), 12);
      load(4'b0011);
      chk_req("R7 preempt 0", 0);
      pulse_ack();
      chk(inserv_o == 4'b1101, "R7 three levels", int'(inserv_o), 13);
      chk_req("R7 all blocked", -1);
      pulse_rtn();
      chk(inserv_o == 4'b1100, "R9 return 1", int'(inserv_o), 12);
      chk_req("R10 next in order", 1);
      pulse_ack();
      chk(inserv_o == 4'b1110, "R10 entered 1", int'(inserv_o), 14);
      pulse_rtn();
      chk(inserv_o == 4'b1100, "R9 return 2", int'(inserv_o), 12);
      pulse_rtn();
      chk(inserv_o == 4'b1000, "R9 return 3", int'(inserv_o), 8);
      pulse_rtn();
      chk(inserv_o == 4'b0000, "R9 return 4", int'(inserv_o), 0);
      pulse_rtn();
      chk(inserv_o == 4'b0000, "R9 idle return", int'(inserv_o), 0);
      chk(pend_o == 4'b0000, "R10 drained", int'(pend_o), 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule